// File: doc/BRIEF.md
# Cascaded Interval Timer With Clear Latch

Three 16-bit down-counters, all in rate-generator mode, sit behind a byte-wide register port. Channel 2 counts a master tick enable and works as a prescaler. Each time it reaches terminal count it produces one count enable, which is shared by channels 0 and 1. A terminal count on channel 0 or channel 1 sets a sticky interrupt flag. Software clears the flags through a separate clear strobe that carries one bit per flag.

Software programs a channel in three steps. It writes a control byte that selects the channel and the two-byte access. It then writes the count low byte first and the high byte second to the channel's data offset. To read a count without a race, software first issues a latch command. The frozen value is then read as two bytes while the channel keeps counting.

Top module: `cascade_timer`

## Requirements
- R1: After reset, both flags on `irq` are 0, every counter holds 0 and is stopped, and a data read returns 0.
- R2: Channel c has its data register at byte offset 4*c+3 (3, 7, 11), and the control register sits at offset 15. In the control byte, bits [7:6] select the channel, and the value 3 makes the whole write ignored. Bits [5:4] give the access: 00 latches the count, 11 arms a low-then-high count load, and 01 or 10 are ignored. Bits [3:0] are not decoded, because rate-generator mode is always used.
- R3: The first data write after arming stores the low byte and stops the channel. The second data write loads the counter with {high, low} in the next cycle. The first decrement happens on the next enabled cycle after that.
- R4: Channel 2 decrements in cycles where `master_tick` is 1. Channels 0 and 1 decrement only in cycles where channel 2 reaches terminal count.
- R5: An enabled cycle that finds the count at 1 is a terminal count, and in that cycle the counter reloads its programmed value. A programmed value N therefore gives one terminal count every N enabled cycles. Channel 2 loaded with 2 gives one enable to channels 0 and 1 for every two master ticks.
- R6: A latch command freezes the current count of the named channel, and the channel keeps counting. The next two data reads return the frozen low byte and then the frozen high byte. The hold ends after the high byte is read. A latch command for a channel that already holds a latch is ignored.
- R7: When no latch is held, data reads return the live count, low byte first and high byte second. A read byte pointer toggles on every read and is reset by a load-arm command or a latch command.
- R8: A terminal count on channel i (i = 0, 1) makes `irq[i]` 1 from the next cycle on. The flag then stays 1 until it is cleared.
- R9: A cycle with `clr_we` = 1 clears every flag whose `clr_bits` bit is 1 and leaves the other flags unchanged, so writing 0x3 clears both flags.
- R10: If a terminal count and a clear of the same flag fall in the same cycle, the flag stays set.
- R11: `bus_rdata` is 0 whenever `bus_addr` is not one of the three data offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_tick | input | 1 | Count enable for channel 2 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; advances the byte pointer |
| bus_addr | input | 4 | Byte offset inside the timer window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and pointer |
| clr_we | input | 1 | Flag clear strobe |
| clr_bits | input | 2 | Per-flag clear mask |
| irq | output | 2 | Sticky terminal-count flags for channels 0 and 1 |

## Verification
The flags are registered, so a terminal count in cycle n shows up on `irq` in cycle n+1. The bench's reference model is advanced at every rising edge, and `irq` is compared with it at every falling edge. Read data is combinational, so each read is checked in the same cycle it is issued, before the edge that moves the byte pointer. A counter load is checked with a read in the first cycle after the high byte is written. The flag timing checks count master ticks from a known state: the sixth tick sets flag 0 and the tenth sets flag 1.

// File: rtl/timer_pkg.sv
package timer_pkg;
   localparam int NCH    = 3;   // channels in the window
   localparam int SRC_CH = 2;   // prescaler channel
   localparam int NFLAG  = 2;   // channels with a flag

   typedef enum logic [1:0] {
      ACC_LATCH = 2'b00,
      ACC_LSB   = 2'b01,
      ACC_MSB   = 2'b10,
      ACC_PAIR  = 2'b11
   } acc_e;

   typedef struct packed {
      logic [1:0] chan;
      acc_e       acc;
      logic [2:0] mode;
      logic       bcd;
   } ctl_t;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          ld_arm,
   input  logic          latch_cmd,
   input  logic          wr,
   input  logic          rd,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          tc
);
   localparam int CW = 2 * DW;

   logic [CW-1:0] cnt_q, reload_q, latv_q;
   logic [DW-1:0] lo_q;
   logic          hi_next_q, run_q, lat_q, rd_hi_q;
   logic          active;
   logic [CW-1:0] view;

   assign active = run_q & en & ~wr;
   assign tc     = active & (cnt_q == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         reload_q  <= '0;
         latv_q    <= '0;
         lo_q      <= '0;
         hi_next_q <= 1'b0;
         run_q     <= 1'b0;
         lat_q     <= 1'b0;
         rd_hi_q   <= 1'b0;
      end else begin
         if (wr) begin
            if (!hi_next_q) begin
               lo_q      <= wdata;
               hi_next_q <= 1'b1;
               run_q     <= 1'b0;
            end else begin
               cnt_q     <= {wdata, lo_q};
               reload_q  <= {wdata, lo_q};
               run_q     <= 1'b1;
               hi_next_q <= 1'b0;
            end
         end else if (active) begin
            cnt_q <= tc ? reload_q : cnt_q - CW'(1);
         end

         if (ld_arm) begin
            hi_next_q <= 1'b0;
            rd_hi_q   <= 1'b0;
         end

         if (latch_cmd && !lat_q) begin
            latv_q  <= cnt_q;
            lat_q   <= 1'b1;
            rd_hi_q <= 1'b0;
         end else if (rd) begin
            rd_hi_q <= ~rd_hi_q;
            if (rd_hi_q) lat_q <= 1'b0;
         end
      end
   end

   assign view  = lat_q ? latv_q : cnt_q;
   assign rdata = rd_hi_q ? view[CW-1:DW] : view[DW-1:0];
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
   parameter int NF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set_i,
   input  logic [NF-1:0] clr_i,
   output logic [NF-1:0] flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) flag_o <= '0;
      else        flag_o <= (flag_o & ~clr_i) | set_i;
   end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
   import timer_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          master_tick,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          clr_we,
   input  logic [1:0]    clr_bits,
   output logic [1:0]    irq
);
   localparam int CTL_OFS = 4 * NCH + 3;

   if (DW < 8) begin : g_bad_dw
      $error("cascade_timer: DW must be at least 8");
   end
   if (AW < 4) begin : g_bad_aw
      $error("cascade_timer: AW must be at least 4");
   end

   ctl_t          ctl;
   logic          ctl_wr;
   logic [NCH-1:0] hit, tc_vec;
   logic [DW-1:0] ch_rd [NCH];

   assign ctl    = ctl_t'(bus_wdata[7:0]);
   assign ctl_wr = bus_wr & (bus_addr == AW'(CTL_OFS)) & (ctl.chan != 2'd3);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic en_c, arm_c, lat_c;
      assign hit[c] = (bus_addr == AW'(4 * c + 3));
      if (c == SRC_CH) begin : g_src
         assign en_c = master_tick;
      end else begin : g_casc
         assign en_c = tc_vec[SRC_CH];
      end
      assign arm_c = ctl_wr & (ctl.chan == 2'(c)) & (ctl.acc == ACC_PAIR);
      assign lat_c = ctl_wr & (ctl.chan == 2'(c)) & (ctl.acc == ACC_LATCH);

      tmr_channel #(.DW(DW)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .en        (en_c),
         .ld_arm    (arm_c),
         .latch_cmd (lat_c),
         .wr        (bus_wr & hit[c]),
         .rd        (bus_rd & ~bus_wr & hit[c]),
         .wdata     (bus_wdata),
         .rdata     (ch_rd[c]),
         .tc        (tc_vec[c])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < NCH; c++)
         if (hit[c]) bus_rdata = ch_rd[c];
   end

   tmr_flags #(.NF(NFLAG)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (tc_vec[NFLAG-1:0]),
      .clr_i  (clr_we ? clr_bits : 2'b00),
      .flag_o (irq)
   );
endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       master_tick,
   input logic [2:0] tc,
   input logic [1:0] irq,
   input logic       clr_we,
   input logic [1:0] clr_bits
);
   assert_src_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tc[2] |-> master_tick);
   assert_cascade_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tc[0] | tc[1]) |-> tc[2]);
   assert_set0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tc[0] |=> irq[0]);
   assert_set1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tc[1] |=> irq[1]);
   assert_hold0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[0] && !(clr_we && clr_bits[0])) |=> irq[0]);
   assert_rise0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[0]) |-> $past(tc[0]));
   assert_clear0_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_bits[0] && !tc[0]) |=> !irq[0]);
   assert_clear1_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_bits[1] && !tc[1]) |=> !irq[1]);
   assert_tc_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_bits[0] && tc[0]) |=> irq[0]);
endmodule

bind cascade_timer cascade_timer_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .master_tick (master_tick),
   .tc          (tc_vec),
   .irq         (irq),
   .clr_we      (clr_we),
   .clr_bits    (clr_bits)
);

// File: tb/test_cascade_timer.sv
module test_cascade_timer;
   logic       clk = 0, rst_n = 0, master_tick = 0, bus_wr = 0, bus_rd = 0;
   logic [3:0] bus_addr = 0;
   logic [7:0] bus_wdata = 0, bus_rdata;
   logic       clr_we = 0;
   logic [1:0] clr_bits = 0, irq;
   int n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   cascade_timer i_cascade_timer (.*);

   // behavioural reference model
   int m_cnt[3], m_rel[3], m_lo[3], m_latv[3];
   bit m_hin[3], m_run[3], m_lat[3], m_rhi[3];
   bit [1:0] m_irq;

   always @(posedge clk) begin
      bit wrc[3];
      bit t[3];
      int cs;
      if (!rst_n) begin
         for (int c = 0; c < 3; c++) begin
            m_cnt[c] = 0; m_rel[c] = 0; m_lo[c] = 0; m_latv[c] = 0;
            m_hin[c] = 0; m_run[c] = 0; m_lat[c] = 0; m_rhi[c] = 0;
         end
         m_irq = 0;
      end else begin
         for (int c = 0; c < 3; c++) wrc[c] = bus_wr && (bus_addr == 4'(4 * c + 3));
         t[2] = m_run[2] && master_tick && !wrc[2] && m_cnt[2] == 1;
         for (int c = 0; c < 2; c++) t[c] = m_run[c] && t[2] && !wrc[c] && m_cnt[c] == 1;
         for (int i = 0; i < 2; i++) m_irq[i] = (m_irq[i] && !(clr_we && clr_bits[i])) || t[i];
         if (bus_wr && bus_addr == 4'd15 && bus_wdata[7:6] != 2'd3) begin
            cs = int'(bus_wdata[7:6]);
            if (bus_wdata[5:4] == 2'd0 && !m_lat[cs]) begin
               m_lat[cs] = 1; m_latv[cs] = m_cnt[cs]; m_rhi[cs] = 0;
            end else if (bus_wdata[5:4] == 2'd3) begin
               m_hin[cs] = 0; m_rhi[cs] = 0;
            end
         end
         for (int c = 0; c < 3; c++) begin
            if (wrc[c]) begin
               if (!m_hin[c]) begin m_lo[c] = bus_wdata; m_hin[c] = 1; m_run[c] = 0; end
               else begin
                  m_cnt[c] = bus_wdata * 256 + m_lo[c]; m_rel[c] = m_cnt[c];
                  m_run[c] = 1; m_hin[c] = 0;
               end
            end else if (m_run[c] && ((c == 2) ? master_tick : t[2])) begin
               m_cnt[c] = t[c] ? m_rel[c] : (m_cnt[c] + 65535) % 65536;
            end
            if (bus_rd && !bus_wr && bus_addr == 4'(4 * c + 3)) begin
               if (m_rhi[c] && m_lat[c]) m_lat[c] = 0;
               m_rhi[c] = !m_rhi[c];
            end
         end
      end
   end

   function automatic int m_rd(input int a);
      int c, v;
      if (a % 4 != 3 || a > 11) return 0;
      c = a / 4;
      v = m_lat[c] ? m_latv[c] : m_cnt[c];
      return m_rhi[c] ? (v / 256) % 256 : v % 256;
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // per-clock flag comparison
   always @(negedge clk) if (rst_n)
      chk(irq === m_irq, "R8", "irq vs model", int'(irq), int'(m_irq));

   task automatic cyc(input bit tk, input bit wr, input int a, input int d,
                      input bit cw, input bit [1:0] cb);
      master_tick = tk; bus_wr = wr; bus_rd = 0; bus_addr = 4'(a);
      bus_wdata = 8'(d); clr_we = cw; clr_bits = cb;
      @(posedge clk); @(negedge clk);
      master_tick = 0; bus_wr = 0; clr_we = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0);
   endtask

   task automatic wr(input int a, input int d);
      cyc(0, 1, a, d, 0, 0);
   endtask

   // read: checked before the edge that advances the pointer; exp < 0 means model only
   task automatic rd(input int a, input int exp, input string req, output int got);
      bus_rd = 1; bus_addr = 4'(a); #1;
      got = int'(bus_rdata);
      chk(got == m_rd(a), req, "read vs model", got, m_rd(a));
      if (exp >= 0) chk(got == exp, req, "read fixed", got, exp);
      @(posedge clk); @(negedge clk);
      bus_rd = 0;
   endtask

   initial begin
      #(200000 * 4);
      chk(0, "WDG", "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int v, lo1, hi1;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(irq == 2'b00, "R1", "irq after reset", int'(irq), 0);
      rd(3, 0, "R1", v);
      rd(3, 0, "R1", v);

      // program ch0=3, ch1=5, ch2=2 (R2 control encoding)
      wr(15, 8'h34); wr(3, 3); wr(3, 0);
      wr(15, 8'h74); wr(7, 5); wr(7, 0);
      wr(15, 8'hB4); wr(11, 2); wr(11, 0);

      ticks(5);
      chk(irq == 2'b00, "R5", "no flag after 5 ticks", int'(irq), 0);
      ticks(1);
      chk(irq == 2'b01, "R4", "flag0 after 6 master ticks", int'(irq), 1);
      ticks(4);
      chk(irq == 2'b11, "R8", "flag1 after 10 ticks, flag0 sticky", int'(irq), 3);

      cyc(0, 0, 0, 0, 1, 2'b01);
      chk(irq == 2'b10, "R9", "clear bit0 only", int'(irq), 2);
      cyc(0, 0, 0, 0, 1, 2'b11);
      chk(irq == 2'b00, "R9", "clear both", int'(irq), 0);

      // tick 12 gives tc on ch0 while clearing both
      ticks(1);
      cyc(1, 0, 0, 0, 1, 2'b11);
      chk(irq == 2'b01, "R10", "terminal count beats clear", int'(irq), 1);

      // latch ch1 (count 4), keep counting
      wr(15, 8'h40);
      ticks(4);
      rd(7, 4, "R6", v);
      rd(7, 0, "R6", v);
      rd(7, 2, "R7", v);
      rd(7, 0, "R7", v);
      wr(15, 8'h40);
      ticks(2);
      wr(15, 8'h40);
      ticks(2);
      rd(7, 2, "R6", v);
      rd(7, 0, "R6", v);
      rd(7, 5, "R7", v);
      rd(7, 0, "R7", v);

      // low byte halts ch0
      wr(15, 8'h34); wr(3, 8'h10);
      rd(3, -1, "R3", lo1);
      rd(3, -1, "R3", hi1);
      ticks(4);
      rd(3, lo1, "R3", v);
      rd(3, hi1, "R3", v);
      wr(3, 0);
      rd(3, 8'h10, "R3", v);
      rd(3, 0, "R3", v);
      ticks(8);
      rd(3, 8'h0C, "R5", v);
      rd(3, 0, "R5", v);

      // ignored control writes
      wr(15, 8'hC0);
      wr(15, 8'h10);
      ticks(2);
      rd(3, 8'h0B, "R2", v);
      rd(3, 0, "R2", v);
      rd(5, 0, "R11", v);
      rd(15, 0, "R11", v);
      ticks(40);
      cyc(0, 0, 0, 0, 0, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule